// File: doc/BRIEF.md
# Program Counter Fetch Unit

The fetch unit holds the processor's program counter and owns the address and read-strobe lines of a memory bus that it shares with a second master. A controller supplies a 3-bit state code. In the PC-update state the counter advances to the next sequential address, or it loads a branch target when the branch flag is set. In every other state the counter keeps its value.

In the three memory-access states the unit stops driving the bus. Both the address lines and the read strobe go to high impedance, so the load/store master can drive them. In all other states the unit drives the current PC and holds the strobe high. The next-sequential address (PC + 1) is a separate output that is always driven. Another stage uses it for return-address capture.

Top module: `fetch_unit`

## Requirements
- R1: Asserting the active-low asynchronous reset `rst_ni` sets the PC to the reset vector, 16'h3000 by default. A reset in the middle of a run does the same.
- R2: `npc_o` always equals the PC plus one, modulo 2^16, so PC 16'hFFFF gives 16'h0000.
- R3: When `state_i` is the PC-update code (7) and `br_taken_i` is 1, the PC loads `br_target_i` on the next rising clock edge.
- R4: When `state_i` is the PC-update code (7) and `br_taken_i` is 0, the PC loads PC + 1 on the next rising clock edge.
- R5: In every state code other than 7, the PC keeps its value, whatever `br_taken_i` and `br_target_i` carry.
- R6: For state codes 0, 1, 2, 6 and 7, `rd_o` is driven to 1 and `pc_o` is driven with the current PC.
- R7: For state codes 3 (indirect address read), 4 (memory read) and 5 (memory write), `rd_o` and `pc_o` are high impedance. A value that another master places on those lines is seen unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| state_i | input | 3 | Controller state code |
| br_target_i | input | 16 | Branch target address |
| br_taken_i | input | 1 | Branch taken flag |
| rd_o | output | 1 | Read strobe to memory; tri-state |
| pc_o | output | 16 | Current PC onto the address bus; tri-state |
| npc_o | output | 16 | PC + 1, always driven |

## Verification
The bench builds the unit with its defaults: a 16-bit PC and reset vector 16'h3000. At this width the bench can reach the wrap from 16'hFFFF to 16'h0000 with a single branch. It can also check the reset value against a known non-zero constant. The bench acts as the second bus master: it drives its own values in the released states and confirms that they reach the bus unchanged. It confirms that the unit alone drives the lines in all other states.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_EXEC   = 3'd2,
    ST_IND_RD = 3'd3,
    ST_MEM_RD = 3'd4,
    ST_MEM_WR = 3'd5,
    ST_WRBACK = 3'd6,
    ST_PC_UPD = 3'd7
  } ctrl_state_e;
endpackage

// File: rtl/fetch_bus_en.sv
module fetch_bus_en
  import fetch_pkg::*;
(
  input  logic [2:0] state_i,
  output logic       bus_en_o,
  output logic       pc_load_o
);
  ctrl_state_e st;
  assign st = ctrl_state_e'(state_i);

  // bus released while the load/store master owns it
  always_comb begin
    unique case (st)
      ST_IND_RD, ST_MEM_RD, ST_MEM_WR: bus_en_o = 1'b0;
      default:                         bus_en_o = 1'b1;
    endcase
  end

  assign pc_load_o = (st == ST_PC_UPD);
endmodule

// File: rtl/fetch_next_pc.sv
module fetch_next_pc #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] pc_i,
  input  logic [W-1:0] target_i,
  input  logic         taken_i,
  output logic [W-1:0] seq_o,
  output logic [W-1:0] next_o
);
  localparam logic [W-1:0] ONE = W'(1);

  assign seq_o  = pc_i + ONE;
  assign next_o = taken_i ? target_i : seq_o;
endmodule

// File: rtl/fetch_pc_reg.sv
module fetch_pc_reg #(
  parameter int unsigned W         = 16,
  parameter logic [W-1:0] RESET_VEC = W'(16'h3000)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= RESET_VEC;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/fetch_unit.sv
module fetch_unit #(
  parameter int unsigned  W         = 16,
  parameter logic [W-1:0] RESET_VEC = W'(16'h3000)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [2:0]   state_i,
  input  logic [W-1:0] br_target_i,
  input  logic         br_taken_i,
  output logic         rd_o,
  output logic [W-1:0] pc_o,
  output logic [W-1:0] npc_o
);
  logic         bus_en;
  logic         pc_load;
  logic [W-1:0] pc_q;
  logic [W-1:0] pc_next;

  fetch_bus_en u_en (
    .state_i  (state_i),
    .bus_en_o (bus_en),
    .pc_load_o(pc_load)
  );

  fetch_next_pc #(.W(W)) u_next (
    .pc_i    (pc_q),
    .target_i(br_target_i),
    .taken_i (br_taken_i),
    .seq_o   (npc_o),
    .next_o  (pc_next)
  );

  fetch_pc_reg #(.W(W), .RESET_VEC(RESET_VEC)) u_pc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(pc_load),
    .d_i   (pc_next),
    .q_o   (pc_q)
  );

  assign rd_o = bus_en ? 1'b1 : 1'bz;
  assign pc_o = bus_en ? pc_q : {W{1'bz}};
endmodule

// File: rtl/fetch_unit_chk.sv
module fetch_unit_chk #(
  parameter int unsigned  W         = 16,
  parameter logic [W-1:0] RESET_VEC = W'(16'h3000)
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [2:0]   state_i,
  input logic [W-1:0] br_target_i,
  input logic         br_taken_i,
  input logic [W-1:0] npc_o,
  input logic [W-1:0] pc_q
);
  assert_reset_vec_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> pc_q == RESET_VEC);

  assert_branch_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 3'd7 && br_taken_i) |=> pc_q == $past(br_target_i));

  // R2 and R4: sequential step lands on the value npc_o showed
  assert_seq_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 3'd7 && !br_taken_i) |=> pc_q == $past(npc_o));

  assert_pc_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != 3'd7) |=> $stable(pc_q));
endmodule

bind fetch_unit fetch_unit_chk #(.W(W), .RESET_VEC(RESET_VEC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .state_i    (state_i),
  .br_target_i(br_target_i),
  .br_taken_i (br_taken_i),
  .npc_o      (npc_o),
  .pc_q       (pc_q)
);

// File: tb/tb_fetch_unit.sv
`timescale 1ns/1ps
module tb_fetch_unit;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [2:0]   state = 3'd0;
  logic [W-1:0] target = '0;
  logic         taken = 1'b0;
  wire          rd_bus;
  wire  [W-1:0] pc_bus;
  logic [W-1:0] npc;
  logic         ext_drv = 1'b0;
  logic [W-1:0] ext_pc = '0;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] model_pc;

  always #10 clk = ~clk;

  assign pc_bus = ext_drv ? ext_pc : {W{1'bz}};
  assign rd_bus = ext_drv ? 1'b0 : 1'bz;

  fetch_unit dut (
    .clk_i(clk), .rst_ni(rst_ni), .state_i(state),
    .br_target_i(target), .br_taken_i(taken),
    .rd_o(rd_bus), .pc_o(pc_bus), .npc_o(npc)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_driven(input string req);
    chk(req, pc_bus, model_pc);
    chk(req, {15'd0, rd_bus}, 16'd1);
    chk("R2", npc, model_pc + 16'd1);
  endtask

  task automatic step(input logic [2:0] st, input logic tk, input logic [W-1:0] tg);
    @(negedge clk);
    state = st; taken = tk; target = tg;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    model_pc = 16'h3000;
    check_driven("R1");
    @(negedge clk); rst_ni = 1'b1;
  endtask

  task automatic t_seq;
    step(3'd7, 1'b0, 16'hDEAD);
    model_pc = model_pc + 16'd1;
    check_driven("R4");
    step(3'd7, 1'b0, 16'h0000);
    model_pc = model_pc + 16'd1;
    check_driven("R4");
  endtask

  task automatic t_branch;
    step(3'd7, 1'b1, 16'h4567);
    model_pc = 16'h4567;
    check_driven("R3");
  endtask

  task automatic t_hold;
    foreach (hold_states[i]) begin
      step(hold_states[i], 1'b1, 16'h1234);
      check_driven("R5");
      check_driven("R6");
    end
  endtask
  logic [2:0] hold_states [4] = '{3'd0, 3'd1, 3'd2, 3'd6};

  task automatic t_release;
    for (int s = 3; s <= 5; s++) begin
      @(negedge clk);
      state = 3'(s); taken = 1'b1; target = 16'h0BAD;
      ext_pc = 16'hA500 + 16'(s); ext_drv = 1'b1;
      #2;
      chk("R7", pc_bus, 16'hA500 + 16'(s));
      chk("R7", {15'd0, rd_bus}, 16'd0);
      @(posedge clk); #1;
      chk("R5", npc, model_pc + 16'd1);
    end
    @(negedge clk);
    ext_drv = 1'b0; state = 3'd0; taken = 1'b0;
    #2;
    check_driven("R6");
  endtask

  task automatic t_wrap;
    step(3'd7, 1'b1, 16'hFFFF);
    model_pc = 16'hFFFF;
    check_driven("R2");
    chk("R2", npc, 16'h0000);
    step(3'd7, 1'b0, 16'h5555);
    model_pc = 16'h0000;
    check_driven("R4");
  endtask

  task automatic t_mid_reset;
    step(3'd2, 1'b0, 16'h0);
    @(negedge clk); rst_ni = 1'b0;
    #2;
    model_pc = 16'h3000;
    check_driven("R1");
    @(negedge clk); rst_ni = 1'b1;
  endtask

  initial begin
    model_pc = 16'h3000;
    t_reset();
    t_seq();
    t_branch();
    t_hold();
    t_release();
    t_wrap();
    t_mid_reset();
    t_seq();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule